// File: doc/BRIEF.md
# Strobe-edge read capture with paired FIFOs

This block takes one byte lane of double-data-rate read data and stores it in two small asynchronous FIFOs. A delayed data strobe clocks both FIFOs. One FIFO stores the beat that is present at each rising strobe edge. The other FIFO stores the beat at each falling edge, and its clock is the inverted strobe. A strobe-aligned read-window input decides whether an edge stores a beat. The data input goes straight into the FIFO storage, with no capture register in front of it.

A system clock shifted by 90 degrees reads both FIFOs. Each write pointer is a Gray count. Two flops in the read clock domain carry it across, and the read side then compares it with its own Gray read pointer to detect empty. When both FIFOs hold a word, the block reads them together and presents one double-width word with a registered valid flag. That word has the falling-edge beat in the upper half and the rising-edge beat in the lower half.

Top module: `ddr_rd_capture`

## Requirements
- R1: While `win_i` is high, a rising edge of `dqs_i` stores the current `dq_i` into the rise FIFO, and a falling edge stores it into the fall FIFO. The value stored is the one present at that edge.
- R2: While `win_i` is low, strobe edges store nothing, and no output word results from them.
- R3: Each output word carries the fall beat in bits [2*DW-1:DW] and the rise beat in bits [DW-1:0]. Words leave in the order they were written, and none is lost or repeated.
- R4: `rd_valid_o` is raised only for a read that found both FIFOs non-empty. A rise entry without a partner waits until a fall entry arrives, and the two then leave together.
- R5: Write pointers are Gray counts, and each crosses through two flops clocked by `clk90_i`. A pair that is complete and unread reaches the output by the fourth rising `clk90_i` edge after its falling-strobe write.
- R6: Both read pointers always move together. At most one pair is read per clock, and back-to-back pairs are read on consecutive clocks.
- R7: The two resets are separate, and each is synchronous to its own clock. After the read reset, `rd_valid_o` is 0 and `rd_data_o` is zero. All pointers start at Gray zero.
- R8: `rd_data_o` keeps its value in every cycle where `rd_valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk90_i | input | 1 | Read-side system clock, 90 degrees shifted |
| rd_rst_i | input | 1 | Active-high read-side reset, synchronous to clk90_i |
| dqs_i | input | 1 | Delayed data strobe; the write clock of both FIFOs |
| wr_rst_i | input | 1 | Active-high write-side reset, synchronous to the strobe |
| win_i | input | 1 | Read window; high lets strobe edges store beats |
| dq_i | input | DW | Data lane from memory |
| rd_valid_o | output | 1 | A new rise/fall pair is on rd_data_o |
| rd_data_o | output | 2*DW | {fall beat, rise beat} |

## Verification
The risky coincidence happens when a strobe write moves a write pointer in the same clock window in which the read side is popping the previous pair. The synchronized pointer then changes under a live empty compare. The bench provokes this with bursts of 2, 4 and 8 beats. Each burst starts at a random sub-cycle phase, so strobe edges sweep all positions relative to `clk90_i`. A behavioural pair of queues judges every output word against the written beats, and it flags any word that appears without both partners.

// File: rtl/ddrcap_pkg.sv
`timescale 1ns/1ps
package ddrcap_pkg;
  typedef enum int {LANE_RISE = 0, LANE_FALL = 1} lane_e;
  localparam int NUM_LANES = 2;

  function automatic logic [31:0] bin2gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction
endpackage

// File: rtl/ddrcap_gray_cnt.sv
`timescale 1ns/1ps
module ddrcap_gray_cnt #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic         inc_i,
  output logic [W-1:0] bin_o,
  output logic [W-1:0] gray_o
);
  import ddrcap_pkg::*;

  logic [W-1:0] bin_nx;
  logic [31:0]  gray_wide;

  assign bin_nx    = bin_o + W'(1);
  assign gray_wide = bin2gray(32'(bin_nx));

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      bin_o  <= '0;
      gray_o <= '0;
    end else if (inc_i) begin
      bin_o  <= bin_nx;
      gray_o <= gray_wide[W-1:0];
    end
  end

  // R5: a pointer that crosses domains never changes more than one bit at a time
  assert_gray_step_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    $countones(gray_o ^ $past(gray_o)) <= 1);
endmodule

// File: rtl/ddrcap_sync2.sv
`timescale 1ns/1ps
module ddrcap_sync2 #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      meta <= '0;
      q_o  <= '0;
    end else begin
      meta <= d_i;
      q_o  <= meta;
    end
  end
endmodule

// File: rtl/ddrcap_lane_fifo.sv
`timescale 1ns/1ps
module ddrcap_lane_fifo #(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input  logic          wclk_i,
  input  logic          wrst_i,
  input  logic          wen_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          rclk_i,
  input  logic          rrst_i,
  input  logic          ren_i,
  output logic [DW-1:0] rdata_o,
  output logic          empty_o,
  output logic [AW-1:0] rptr_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wbin, wgray, wgray_sync, rbin, rgray;

  // write side: strobe domain, data stored straight from the pins
  ddrcap_gray_cnt #(.W(AW)) u_wptr (
    .clk_i(wclk_i), .rst_i(wrst_i), .inc_i(wen_i),
    .bin_o(wbin), .gray_o(wgray));

  always_ff @(posedge wclk_i) begin
    if (wen_i) mem[wbin] <= wdata_i;
  end

  // R2: a closed window leaves the write pointer where it was
  assert_hold_closed_R2: assert property (@(posedge wclk_i) disable iff (wrst_i)
    !wen_i |=> $stable(wgray));

  // read side: system clock domain
  ddrcap_sync2 #(.W(AW)) u_wsync (
    .clk_i(rclk_i), .rst_i(rrst_i), .d_i(wgray), .q_o(wgray_sync));

  ddrcap_gray_cnt #(.W(AW)) u_rptr (
    .clk_i(rclk_i), .rst_i(rrst_i), .inc_i(ren_i),
    .bin_o(rbin), .gray_o(rgray));

  assign empty_o = (rgray == wgray_sync);
  assign rptr_o  = rgray;

  always_ff @(posedge rclk_i) begin
    if (rrst_i)     rdata_o <= '0;
    else if (ren_i) rdata_o <= mem[rbin];
  end
endmodule

// File: rtl/ddr_rd_capture.sv
`timescale 1ns/1ps
module ddr_rd_capture #(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input  logic            clk90_i,
  input  logic            rd_rst_i,
  input  logic            dqs_i,
  input  logic            wr_rst_i,
  input  logic            win_i,
  input  logic [DW-1:0]   dq_i,
  output logic            rd_valid_o,
  output logic [2*DW-1:0] rd_data_o
);
  import ddrcap_pkg::*;

  logic [DW-1:0] lane_q     [NUM_LANES];
  logic          lane_empty [NUM_LANES];
  logic [AW-1:0] lane_rptr  [NUM_LANES];
  logic          pair_rd;

  assign pair_rd = !lane_empty[LANE_RISE] && !lane_empty[LANE_FALL];

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    logic wclk;
    if (g == int'(LANE_FALL)) begin : g_inv
      assign wclk = ~dqs_i;
    end else begin : g_dir
      assign wclk = dqs_i;
    end

    ddrcap_lane_fifo #(.DW(DW), .AW(AW)) u_fifo (
      .wclk_i(wclk), .wrst_i(wr_rst_i), .wen_i(win_i), .wdata_i(dq_i),
      .rclk_i(clk90_i), .rrst_i(rd_rst_i), .ren_i(pair_rd),
      .rdata_o(lane_q[g]), .empty_o(lane_empty[g]), .rptr_o(lane_rptr[g]));
  end

  always_ff @(posedge clk90_i) begin
    if (rd_rst_i) rd_valid_o <= 1'b0;
    else          rd_valid_o <= pair_rd;
  end

  assign rd_data_o = {lane_q[LANE_FALL], lane_q[LANE_RISE]};

  // R6: the two read pointers never drift apart
  assert_lockstep_R6: assert property (@(posedge clk90_i) disable iff (rd_rst_i)
    lane_rptr[LANE_RISE] == lane_rptr[LANE_FALL]);

  // R8: no new word means the output word holds
  assert_hold_data_R8: assert property (@(posedge clk90_i) disable iff (rd_rst_i)
    !rd_valid_o |-> $stable(rd_data_o));

  // R7: leaving read reset, the output is quiet and zero
  assert_reset_out_R7: assert property (@(posedge clk90_i) disable iff (rd_rst_i)
    $fell(rd_rst_i) |-> (!rd_valid_o && rd_data_o == '0));
endmodule

// File: tb/ddr_rd_capture_tb.sv
`timescale 1ns/1ps
module ddr_rd_capture_tb;
  localparam int DW = 8;
  localparam int AW = 4;

  logic clk = 1'b0;
  logic rd_rst = 1'b1, wr_rst = 1'b1;
  logic dqs = 1'b0, win = 1'b0;
  logic [DW-1:0] dq = '0;
  logic rd_valid;
  logic [2*DW-1:0] rd_data;

  int checks = 0, errors = 0, n_out = 0;
  logic [DW-1:0] rise_q[$];
  logic [DW-1:0] fall_q[$];

  always #10 clk = ~clk;

  ddr_rd_capture #(.DW(DW), .AW(AW)) u_dut (
    .clk90_i(clk), .rd_rst_i(rd_rst), .dqs_i(dqs), .wr_rst_i(wr_rst),
    .win_i(win), .dq_i(dq), .rd_valid_o(rd_valid), .rd_data_o(rd_data));

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // reference model: every output word compared on every clock
  always @(negedge clk) begin
    if (!rd_rst && rd_valid) begin
      n_out++;
      if (rise_q.size() == 0 || fall_q.size() == 0)
        check(0, "R4 word without both partners", longint'(rd_data), 0);
      else begin
        logic [DW-1:0] f, r;
        f = fall_q.pop_front();
        r = rise_q.pop_front();
        check(rd_data == {f, r}, "R3 pair order/content", longint'(rd_data), longint'({f, r}));
      end
    end
  end

  // one strobe cycle; each half chooses whether its edge stores a beat
  task automatic strobe_cycle(input bit wr_r, input logic [DW-1:0] dr,
                              input bit wr_f, input logic [DW-1:0] df);
    win = wr_r; dq = dr;
    #5 dqs = 1'b1; if (wr_r) rise_q.push_back(dr);
    #5 win = wr_f; dq = df;
    #5 dqs = 1'b0; if (wr_f) fall_q.push_back(df);
    #5 win = 1'b0;
  endtask

  task automatic burst(input int beats);
    real ph;
    ph = real'($urandom_range(0, 19)) + 0.3;
    #(ph);
    for (int i = 0; i < beats / 2; i++)
      strobe_cycle(1'b1, DW'($urandom), 1'b1, DW'($urandom));
  endtask

  task automatic settle();
    repeat (5) @(posedge clk);
    @(negedge clk); #2;
  endtask

  initial begin
    #(3_000_000);
    errors++;
    $display("FAIL watchdog expired at %0t", $time);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int base;
    // both resets held, strobe toggles so its reset is seen
    for (int i = 0; i < 3; i++) strobe_cycle(1'b0, '0, 1'b0, '0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    wr_rst = 1'b0; rd_rst = 1'b0;
    #2;
    check(rd_valid == 1'b0, "R7 valid low after reset", rd_valid, 0);
    check(rd_data == '0, "R7 data zero after reset", rd_data, 0);

    // R2: edges with a closed window store nothing
    base = n_out;
    for (int i = 0; i < 4; i++) strobe_cycle(1'b0, 8'hA5, 1'b0, 8'h5A);
    settle();
    check(n_out == base, "R2 closed window produced output", n_out - base, 0);

    // R1 R3 R5 R6: bursts of 2, 4, 8 beats at random phase
    for (int k = 0; k < 30; k++) begin
      int beats;
      beats = (k % 3 == 0) ? 2 : ((k % 3 == 1) ? 4 : 8);
      base = n_out;
      burst(beats);
      settle();
      check(rise_q.size() == 0 && fall_q.size() == 0, "R5 pairs drained in time",
            rise_q.size() + fall_q.size(), 0);
      check(n_out - base == beats / 2, "R1 one word per strobe cycle", n_out - base, beats / 2);
    end

    // R6: two 8-beat bursts back to back, one pair per clock
    base = n_out;
    burst(8);
    for (int i = 0; i < 4; i++) strobe_cycle(1'b1, DW'($urandom), 1'b1, DW'($urandom));
    settle();
    check(n_out - base == 8, "R6 back-to-back pairs", n_out - base, 8);

    // R4: lone rise entry waits for a partner
    base = n_out;
    strobe_cycle(1'b1, 8'h3C, 1'b0, 8'h00);
    settle();
    check(n_out == base, "R4 lone rise held", n_out - base, 0);
    check(rise_q.size() == 1, "R4 rise entry pending", rise_q.size(), 1);
    strobe_cycle(1'b0, 8'h00, 1'b1, 8'hC3);
    settle();
    check(n_out - base == 1, "R4 partnered pair released", n_out - base, 1);
    check(rd_data == 16'hC33C, "R3 fall high rise low", rd_data, 16'hC33C);

    // R8: output word holds while idle
    repeat (4) begin
      @(negedge clk); #2;
      check(rd_valid == 0 && rd_data == 16'hC33C, "R8 idle hold", rd_data, 16'hC33C);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule